// File: doc/BRIEF.md
# Seven-Pin Bidirectional GPIO Port

This block gives software seven general-purpose pins behind a small register bus. Each pin can be an input or an output. For each pin the block drives an output enable and an output value to an external tri-state pad, and it samples the level coming back from the pad. Three registers sit on the bus. The direction register holds one bit per pin, where 1 means input. The output latch register holds the value the pins drive. The pin register returns the synchronized pad levels on a read, and it loads the output latch on a write. Because the latch has its own read path, a read-modify-write sequence acts on the driven value and not on whatever the pins happen to show.

An external control source supplies a per-pin analog-mode mask. Pins in analog mode read as zero through the pin register. Their drivers still follow the direction bits, so software keeps those bits at 1 for analog use. The control source comes out of reset with the mask at `0101111`, meaning pins 5 and 3..0 are analog and pins 6 and 4 are digital. Pin 4 has an open-drain output. It can only pull its pad low, and it lets the pad float whenever its latch bit is 1.

Top module: `gpio_port`

## Requirements
- R1: After reset every direction bit is 1 and every latch bit is 0. Reading address 2 returns 0x7F, reading address 1 returns 0x00, and `padOe` is all zeros.
- R2: For every pin except pin 4, `padOe[i]` is the inverse of direction bit i, and `padOut[i]` equals latch bit i.
- R3: Reading address 0 returns the pad inputs after a two-flop synchronizer. A pad change made between edges appears after the second rising edge and not after the first.
- R4: A write to address 0 loads the output latch with data bits 6..0.
- R5: Reading address 1 returns the latch contents, even when the pins show a different level.
- R6: `padOut[4]` is always 0. `padOe[4]` is 1 only when direction bit 4 is 0 and latch bit 4 is 0.
- R7: When `analogMask[i]` is 1, bit i of an address-0 read is 0. Reads of addresses 1 and 2 do not depend on the mask.
- R8: The direction bits drive `padOe` whether or not a pin is in analog mode.
- R9: Bit 7 of every read is 0. Address 3 reads 0x00, and a write to address 3 changes no register.
- R10: Reads are combinational on the current address. A write to address 2 (direction) or address 1 (latch) takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address (0 pin, 1 latch, 2 direction, 3 unused) |
| busWe | input | 1 | Write enable; the write is applied at the rising edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data for `busAddr` |
| analogMask | input | 7 | Per-pin analog-mode select (1 = analog) |
| padIn | input | 7 | Level sampled from each pad |
| padOe | output | 7 | Pad output enable (1 = drive) |
| padOut | output | 7 | Value driven when enabled |

## Verification
A write to the pin register and a read of that same register can happen in one cycle. In that cycle the read must return the synchronized pad level and not the data being written, and the written data must show up in the latch from the next edge onward. The bench provokes this by holding the pads at a pattern different from the write data. It compares `busRdata` during the write cycle against that pad pattern, and afterwards reads the latch to compare it against the write data.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [1:0] ADDR_PIN = 2'd0;
  localparam logic [1:0] ADDR_LAT = 2'd1;
  localparam logic [1:0] ADDR_DIR = 2'd2;

  typedef enum logic [1:0] {
    SEL_PIN  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_NONE = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   latWe;
    logic   dirWe;
    rdSel_e rdSel;
  } gpioStrobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic [1:0]  busAddr,
  input  logic        busWe,
  output gpioStrobe_t strobe
);
  always_comb begin
    strobe = '{latWe: 1'b0, dirWe: 1'b0, rdSel: SEL_NONE};
    unique case (busAddr)
      ADDR_PIN: begin
        strobe.rdSel = SEL_PIN;
        strobe.latWe = busWe;
      end
      ADDR_LAT: begin
        strobe.rdSel = SEL_LAT;
        strobe.latWe = busWe;
      end
      ADDR_DIR: begin
        strobe.rdSel = SEL_DIR;
        strobe.dirWe = busWe;
      end
      default: strobe.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 7,
  parameter int DATA_W      = 8,
  parameter int OD_BIT      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpioStrobe_t       strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [WIDTH-1:0]  analogMask,
  input  logic [WIDTH-1:0]  padIn,
  output logic [DATA_W-1:0] busRdata,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padOut
);
  localparam int PAD_W = DATA_W - WIDTH;

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] latReg;
  logic [WIDTH-1:0] syncStage [SYNC_STAGES];
  logic [WIDTH-1:0] pinLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg <= '1;
      latReg <= '0;
    end else begin
      if (strobe.dirWe) dirReg <= busWdata[WIDTH-1:0];
      if (strobe.latWe) latReg <= busWdata[WIDTH-1:0];
    end
  end

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncStage[s] <= '0;
        else if (s == 0) syncStage[s] <= padIn;
        else syncStage[s] <= syncStage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinLevel = syncStage[SYNC_STAGES-1] & ~analogMask;

  genvar p;
  generate
    for (p = 0; p < WIDTH; p++) begin : g_pad
      if (p == OD_BIT) begin : g_od
        assign padOe[p]  = ~dirReg[p] & ~latReg[p];
        assign padOut[p] = 1'b0;
      end else begin : g_pp
        assign padOe[p]  = ~dirReg[p];
        assign padOut[p] = latReg[p];
      end
    end
  endgenerate

  always_comb begin
    unique case (strobe.rdSel)
      SEL_PIN: busRdata = {{PAD_W{1'b0}}, pinLevel};
      SEL_LAT: busRdata = {{PAD_W{1'b0}}, latReg};
      SEL_DIR: busRdata = {{PAD_W{1'b0}}, dirReg};
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 7,
  parameter int DATA_W      = 8,
  parameter int OD_BIT      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [WIDTH-1:0]  analogMask,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padOut
);
  gpioStrobe_t strobe;

  gpio_ctrl ctrl_i (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strobe (strobe)
  );

  gpio_datapath #(
    .WIDTH(WIDTH), .DATA_W(DATA_W), .OD_BIT(OD_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .analogMask(analogMask),
    .padIn     (padIn),
    .busRdata  (busRdata),
    .padOe     (padOe),
    .padOut    (padOut)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH  = 7,
  parameter int DATA_W = 8,
  parameter int OD_BIT = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [WIDTH-1:0]  analogMask,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padOut
);
  localparam logic [WIDTH-1:0] PP_MASK = ~(WIDTH'(1) << OD_BIT);

  // R6
  od_low_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    padOut[OD_BIT] == 1'b0);

  // R9
  top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[DATA_W-1] == 1'b0);

  // R7
  analog_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0) |-> ((busRdata[WIDTH-1:0] & analogMask) == '0));

  // R10
  latch_write_next_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd1) |=>
      ((padOut & PP_MASK) == ($past(busWdata[WIDTH-1:0]) & PP_MASK)));

  // R2
  dir_write_drives_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd2) |=>
      ((padOe & PP_MASK) == (~$past(busWdata[WIDTH-1:0]) & PP_MASK)));

  // R9
  unused_addr_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 2'd3) |=> ($stable(padOe) && $stable(padOut)));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .DATA_W(DATA_W), .OD_BIT(OD_BIT)) chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .busRdata(busRdata), .analogMask(analogMask), .padOe(padOe), .padOut(padOut)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] busAddr;
  logic       busWe;
  logic [7:0] busWdata;
  logic [7:0] busRdata;
  logic [6:0] analogMask;
  logic [6:0] padIn;
  logic [6:0] padOe;
  logic [6:0] padOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .analogMask(analogMask), .padIn(padIn),
    .padOe(padOe), .padOut(padOut)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] v;
    rdReg(2'd2, v); check("R1 dir", v, 8'h7F);
    rdReg(2'd1, v); check("R1 latch", v, 8'h00);
    check("R1 padOe", {1'b0, padOe}, 8'h00);
  endtask

  task automatic testDrive();
    wrReg(2'd1, 8'h2B);
    wrReg(2'd2, 8'h00);
    #1;
    check("R2 padOe", {1'b0, padOe & 7'h6F}, 8'h6F);
    check("R2 padOut", {1'b0, padOut & 7'h6F}, 8'h2B);
    wrReg(2'd2, 8'h0F);
    #1 check("R10 padOe after dir write", {1'b0, padOe & 7'h6F}, 8'h60);
  endtask

  task automatic testSync();
    logic [7:0] v;
    analogMask = 7'h00;
    padIn = 7'h00;
    settle();
    @(negedge clk); padIn = 7'h5A; busAddr = 2'd0;
    @(negedge clk); #1 check("R3 after one edge", busRdata, 8'h00);
    @(negedge clk); #1 check("R3 after two edges", busRdata, 8'h5A);
    rdReg(2'd0, v); check("R9 bit7 pin read", v & 8'h80, 8'h00);
  endtask

  task automatic testPortWrite();
    logic [7:0] v;
    wrReg(2'd0, 8'hB3);
    rdReg(2'd1, v); check("R4 latch from port write", v, 8'h33);
    check("R9 bit7 latch read", v & 8'h80, 8'h00);
  endtask

  task automatic testLatchVsPin();
    logic [7:0] v;
    wrReg(2'd2, 8'h7F);
    wrReg(2'd1, 8'h15);
    padIn = 7'h6A; settle();
    rdReg(2'd1, v); check("R5 latch read", v, 8'h15);
    rdReg(2'd0, v); check("R5 pin read differs", v, 8'h6A);
  endtask

  task automatic testOpenDrain();
    wrReg(2'd2, 8'h6F);
    wrReg(2'd1, 8'h00);
    #1 check("R6 od low drive", {6'd0, padOe[4], padOut[4]}, 8'h02);
    wrReg(2'd1, 8'h10);
    #1 check("R6 od release", {6'd0, padOe[4], padOut[4]}, 8'h00);
    wrReg(2'd2, 8'h7F);
    wrReg(2'd1, 8'h00);
    #1 check("R6 od input", {7'd0, padOe[4]}, 8'h00);
  endtask

  task automatic testAnalog();
    logic [7:0] v;
    analogMask = 7'h2F;
    padIn = 7'h7F; settle();
    rdReg(2'd0, v); check("R7 analog pins zero", v, 8'h50);
    wrReg(2'd1, 8'h2A);
    rdReg(2'd1, v); check("R7 latch unaffected", v, 8'h2A);
    rdReg(2'd2, v); check("R7 dir unaffected", v, 8'h7F);
    wrReg(2'd2, 8'h7C);
    #1 check("R8 analog pins still driven", {1'b0, padOe}, 8'h03);
    wrReg(2'd2, 8'h7F);
    analogMask = 7'h00;
  endtask

  task automatic testUnused();
    logic [7:0] v;
    logic [6:0] oe0, out0;
    wrReg(2'd2, 8'h55);
    wrReg(2'd1, 8'h0A);
    #1 oe0 = padOe; out0 = padOut;
    wrReg(2'd3, 8'hFF);
    #1 check("R9 oe stable after addr3 write", {1'b0, padOe}, {1'b0, oe0});
    check("R9 out stable after addr3 write", {1'b0, padOut}, {1'b0, out0});
    rdReg(2'd3, v); check("R9 addr3 reads zero", v, 8'h00);
    rdReg(2'd2, v); check("R9 dir kept", v, 8'h55);
    rdReg(2'd1, v); check("R9 latch kept", v, 8'h0A);
  endtask

  task automatic testSameCycle();
    logic [7:0] v;
    analogMask = 7'h00;
    padIn = 7'h2A; settle();
    @(negedge clk);
    busAddr = 2'd0; busWe = 1'b1; busWdata = 8'h55;
    #1 check("R10 pin read during write", busRdata, 8'h2A);
    @(negedge clk); busWe = 1'b0;
    rdReg(2'd1, v); check("R4 latch after same-cycle write", v, 8'h55);
  endtask

  initial begin
    rstN = 1'b0; busAddr = 2'd0; busWe = 1'b0; busWdata = 8'h00;
    analogMask = 7'h2F; padIn = 7'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDrive();
    testSync();
    testPortWrite();
    testLatchVsPin();
    testOpenDrain();
    testAnalog();
    testUnused();
    testSameCycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule